// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

The walker drives a DMA transfer from a table of region descriptors held in memory. Software writes the table base address and the transfer direction, then raises the run input. The walker reads each 8-byte descriptor as two little-endian dwords through a single-dword read port. The first dword is the physical start address of a region. The second dword carries the byte count in its low 16 bits and an end-of-table flag in bit 31.

For each valid descriptor the walker presents one request to an external data mover and holds it until the mover signals completion. The request carries the region address, the length expanded to 17 bits and the direction. The walker then steps its table pointer by 8 and fetches the next entry. After the flagged entry completes, the walker reports done. It reports an error instead when a read fails, when a region is misaligned, or when a region would cross a 64 KB boundary.

Both status flags stay set until the run input is dropped. Dropping the run input at any point abandons the walk and returns the block to idle.

Top module: `prd_walker`

## Requirements
- R1: While reset is asserted and after its release with run low, busy_o, done_o, err_o, mem_req_o and xfer_req_o are all low.
- R2: A walk reads dword 0 of a descriptor at the pointer and dword 1 at pointer+4, each read held until mem_rvalid_i; the pointer starts at table_base_i and advances by 8 per descriptor.
- R3: Each accepted descriptor raises xfer_req_o with xfer_addr_o equal to dword 0, xfer_len_o equal to dword 1 bits 15:0 and xfer_dir_o equal to dir_i sampled at the start; the request holds until xfer_done_i.
- R4: A count field of 0 produces xfer_len_o = 65536 (17'h10000).
- R5: A descriptor with dword 1 bit 31 set is the last; done_o rises in the cycle after xfer_done_i completes its transfer, and no further read is made.
- R6: A region address with bit 0 set raises err_o and issues no transfer for that descriptor.
- R7: A region whose address bits 15:0 plus its length exceed 65536 raises err_o and issues no transfer for it; ending exactly on the boundary is accepted.
- R8: mem_err_i returned with mem_rvalid_i on either dword read raises err_o and ends the walk.
- R9: Dropping start_i in any state makes busy_o, done_o, err_o, mem_req_o and xfer_req_o low from the next cycle on, with no further requests.
- R10: busy_o is high from the first fetch until done_o or err_o is raised; busy_o, done_o and err_o are never high together, and done_o and err_o are mutually exclusive.
- R11: mem_req_o and xfer_req_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run control; the walk proceeds only while high |
| dir_i | input | 1 | Transfer direction, captured at walk start |
| table_base_i | input | AW | Address of the first descriptor |
| mem_req_o | output | 1 | Dword read request |
| mem_addr_o | output | AW | Dword read address |
| mem_rvalid_i | input | 1 | Read data valid; completes the request |
| mem_rdata_i | input | 32 | Read data |
| mem_err_i | input | 1 | Read failed; qualified by mem_rvalid_i |
| xfer_req_o | output | 1 | Region transfer request to the data mover |
| xfer_addr_o | output | AW | Region start address |
| xfer_len_o | output | CNT_W+1 | Region length in bytes |
| xfer_dir_o | output | 1 | Region transfer direction |
| xfer_done_i | input | 1 | Data mover has finished the current region |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Table finished without error |
| err_o | output | 1 | Walk stopped on an error |

## Verification
A single-entry table checks the basic fetch, request and done timing, with the direction bit set one way. A three-entry chain, run with the opposite direction, mixes a zero count, a region that ends exactly on a 64 KB boundary and an ordinary region. This separates the length expansion from the boundary rule and confirms the pointer stride. Error runs place a misaligned address, a region one byte over the boundary, and a failing read behind a good entry, which shows that earlier transfers still complete and that nothing follows the fault. An abort while the data mover stalls shows that the run input cuts the walk off in any state.

// File: rtl/prd_pkg.sv
package prd_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH0,
    S_FETCH1,
    S_XFER,
    S_NEXT,
    S_DONE
  } walk_state_e;

  localparam int unsigned DWORD_W    = 32;
  localparam int unsigned LAST_BIT   = 31;
  localparam int unsigned DESC_BYTES = 8;
endpackage

// File: rtl/prd_ptr.sv
module prd_ptr #(
  parameter int unsigned AW     = 32,
  parameter int unsigned STRIDE = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] STEP = AW'(STRIDE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= base_i;
    else if (step_i) ptr_o <= ptr_o + STEP;
  end
endmodule

// File: rtl/prd_check.sv
module prd_check #(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W:0]   len_o,
  output logic             bad_o
);
  localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W:0] end_off;

  // zero count stands for a full window
  always_comb begin
    len_o   = (cnt_i == '0) ? FULL : {1'b0, cnt_i};
    end_off = {1'b0, addr_i[CNT_W-1:0]} + len_o;
    bad_o   = addr_i[0] | (end_off > FULL);
  end
endmodule

// File: rtl/prd_walker.sv
module prd_walker #(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             dir_i,
  input  logic [AW-1:0]    table_base_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [31:0]      mem_rdata_i,
  input  logic             mem_err_i,
  output logic             xfer_req_o,
  output logic [AW-1:0]    xfer_addr_o,
  output logic [CNT_W:0]   xfer_len_o,
  output logic             xfer_dir_o,
  input  logic             xfer_done_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  import prd_pkg::*;

  localparam logic [AW-1:0] HI_OFF = AW'(DESC_BYTES / 2);

  walk_state_e      state_q, state_d;
  logic [AW-1:0]    ptr;
  logic [AW-1:0]    addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_q, dir_q, err_q;
  logic             load, step;
  logic             new_bad;
  logic [CNT_W:0]   new_len;

  prd_ptr #(.AW(AW), .STRIDE(DESC_BYTES)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .base_i (table_base_i),
    .step_i (step),
    .ptr_o  (ptr)
  );

  // validates the count arriving on the read bus against the latched address
  prd_check #(.AW(AW), .CNT_W(CNT_W)) u_chk_in (
    .addr_i (addr_q),
    .cnt_i  (mem_rdata_i[CNT_W-1:0]),
    .len_o  (new_len),
    .bad_o  (new_bad)
  );

  logic unused_bad;
  prd_check #(.AW(AW), .CNT_W(CNT_W)) u_chk_out (
    .addr_i (addr_q),
    .cnt_i  (cnt_q),
    .len_o  (xfer_len_o),
    .bad_o  (unused_bad)
  );

  logic rd_ok, rd_bad;
  assign rd_ok  = mem_rvalid_i & ~mem_err_i;
  assign rd_bad = mem_rvalid_i &  mem_err_i;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step    = 1'b0;
    if (!start_i) begin
      state_d = S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          load    = 1'b1;
          state_d = S_FETCH0;
        end
        S_FETCH0: if (rd_bad) state_d = S_DONE;
                  else if (rd_ok) state_d = S_FETCH1;
        S_FETCH1: if (rd_bad || (rd_ok && new_bad)) state_d = S_DONE;
                  else if (rd_ok) state_d = S_XFER;
        S_XFER:   if (xfer_done_i) state_d = last_q ? S_DONE : S_NEXT;
        S_NEXT: begin
          step    = 1'b1;
          state_d = S_FETCH0;
        end
        S_DONE:   state_d = S_DONE;
        default:  state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      last_q  <= 1'b0;
      dir_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE) begin
        err_q <= 1'b0;
        dir_q <= dir_i;
      end
      if (start_i && (state_q == S_FETCH0) && rd_ok) addr_q <= mem_rdata_i[AW-1:0];
      if (start_i && (state_q == S_FETCH1) && rd_ok) begin
        cnt_q  <= mem_rdata_i[CNT_W-1:0];
        last_q <= mem_rdata_i[LAST_BIT];
      end
      if (start_i && (((state_q == S_FETCH0 || state_q == S_FETCH1) && rd_bad) ||
                      (state_q == S_FETCH1 && rd_ok && new_bad)))
        err_q <= 1'b1;
    end
  end

  assign mem_req_o   = (state_q == S_FETCH0) || (state_q == S_FETCH1);
  assign mem_addr_o  = (state_q == S_FETCH1) ? ptr + HI_OFF : ptr;
  assign xfer_req_o  = (state_q == S_XFER);
  assign xfer_addr_o = addr_q;
  assign xfer_dir_o  = dir_q;
  assign busy_o      = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done_o      = (state_q == S_DONE) && !err_q;
  assign err_o       = (state_q == S_DONE) &&  err_q;
endmodule

// File: rtl/prd_walker_chk.sv
module prd_walker_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             mem_req_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic             mem_rvalid_i,
  input logic             xfer_req_o,
  input logic [AW-1:0]    xfer_addr_o,
  input logic [CNT_W:0]   xfer_len_o,
  input logic             xfer_done_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o
);
  localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

  assert_req_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_o, xfer_req_o}));

  assert_status_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, done_o, err_o}));

  assert_rd_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i && start_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_xfer_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_done_i && start_i) |=> (xfer_req_o && $stable(xfer_addr_o)));

  assert_align_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> (xfer_addr_o[0] == 1'b0));

  assert_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> (({1'b0, xfer_addr_o[CNT_W-1:0]} + xfer_len_o) <= FULL));

  assert_done_after_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(xfer_done_i && xfer_req_o));

  assert_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !(busy_o || done_o || err_o || mem_req_o || xfer_req_o));
endmodule

bind prd_walker prd_walker_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .xfer_req_o   (xfer_req_o),
  .xfer_addr_o  (xfer_addr_o),
  .xfer_len_o   (xfer_len_o),
  .xfer_done_i  (xfer_done_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/prd_walker_tb.sv
module prd_walker_tb;
  localparam int AW = 32;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, dir = 1'b0;
  logic [AW-1:0] tbase = '0;
  logic mem_req, mem_rvalid = 1'b0, mem_err = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic xfer_req, xfer_dir, xfer_done = 1'b0;
  logic [AW-1:0] xfer_addr;
  logic [CNT_W:0] xfer_len;
  logic busy, done, err;

  always #4 clk = ~clk;

  prd_walker #(.AW(AW), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_i(dir), .table_base_i(tbase),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .mem_err_i(mem_err),
    .xfer_req_o(xfer_req), .xfer_addr_o(xfer_addr), .xfer_len_o(xfer_len),
    .xfer_dir_o(xfer_dir), .xfer_done_i(xfer_done),
    .busy_o(busy), .done_o(done), .err_o(err));

  int checks = 0, errors = 0;
  logic [31:0] mem [64];
  logic        fail_en = 1'b0;
  logic [AW-1:0] fail_addr = '0;
  logic        hold = 1'b0;
  int cyc = 0, done_cyc = 0;
  int nrd = 0, nxf = 0;
  logic [AW-1:0] rd_log [64];
  logic [AW-1:0] xa_log [16];
  logic [CNT_W:0] xl_log [16];
  logic        xd_log [16];

  // memory and data mover models
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      xfer_done  <= 1'b0;
    end else begin
      mem_rvalid <= mem_req && !mem_rvalid;
      mem_rdata  <= mem[mem_addr[7:2]];
      mem_err    <= mem_req && !mem_rvalid && fail_en && (mem_addr == fail_addr);
      if (mem_req && mem_rvalid) begin
        rd_log[nrd[5:0]] <= mem_addr;
        nrd <= nrd + 1;
      end
      xfer_done <= xfer_req && !xfer_done && !hold;
      if (xfer_req && xfer_done) begin
        xa_log[nxf[3:0]] <= xfer_addr;
        xl_log[nxf[3:0]] <= xfer_len;
        xd_log[nxf[3:0]] <= xfer_dir;
        nxf <= nxf + 1;
        done_cyc <= cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = '0;
  endtask

  // run a table to completion; returns cycle done_o first seen
  task automatic run(input logic [AW-1:0] base, input logic d, output int seen);
    seen = -1;
    @(negedge clk);
    tbase = base; dir = d; start = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done || err) begin seen = cyc; break; end
    end
  endtask

  task automatic stop_run(input string tag);
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !mem_req && !xfer_req, tag,
        {busy, done, err, mem_req, xfer_req}, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(!busy && !done && !err && !mem_req && !xfer_req, "R1 during reset",
        {busy, done, err, mem_req, xfer_req}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !mem_req && !xfer_req, "R1 idle after reset",
        {busy, done, err, mem_req, xfer_req}, 0);
  endtask

  task automatic t_single();
    int r0, x0, seen;
    clear_mem();
    mem[2] = 32'h0000_4000; mem[3] = 32'h8000_0100;
    r0 = nrd; x0 = nxf;
    @(negedge clk); tbase = 32'h8; dir = 1'b1; start = 1'b1;
    @(negedge clk);
    chk(busy, "R10 busy during walk", {31'b0, busy}, 1);
    seen = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done || err) begin seen = cyc; break; end
    end
    chk(done && !err, "R5 single entry done", {done, err}, 2'b10);
    chk(seen == done_cyc + 1, "R5 done one cycle after completion", seen, done_cyc + 1);
    chk(nrd - r0 == 2 && rd_log[r0[5:0]] == 32'h8 && rd_log[r0[5:0]+1] == 32'hC,
        "R2 two reads at base, base+4", rd_log[r0[5:0]+1], 32'hC);
    chk(nxf - x0 == 1 && xa_log[x0[3:0]] == 32'h4000 && xl_log[x0[3:0]] == 17'h100,
        "R3 single request fields", xa_log[x0[3:0]], 32'h4000);
    chk(xd_log[x0[3:0]] == 1'b1, "R3 direction one", {31'b0, xd_log[x0[3:0]]}, 1);
    repeat (4) @(negedge clk);
    chk(nrd - r0 == 2 && done, "R5 no read after last entry", nrd - r0, 2);
    stop_run("R9 clear after done");
  endtask

  task automatic t_chain();
    int r0, x0, seen;
    clear_mem();
    mem[16] = 32'h0001_0000; mem[17] = 32'h0000_0000;
    mem[18] = 32'h0002_FFF0; mem[19] = 32'h0000_0010;
    mem[20] = 32'h1234_0100; mem[21] = 32'h8000_0200;
    r0 = nrd; x0 = nxf;
    run(32'h40, 1'b0, seen);
    chk(done && !err, "R5 chain done", {done, err}, 2'b10);
    chk(nxf - x0 == 3, "R3 chain transfer count", nxf - x0, 3);
    chk(xa_log[x0[3:0]] == 32'h0001_0000 && xl_log[x0[3:0]] == 17'h10000,
        "R4 zero count is 65536", {15'b0, xl_log[x0[3:0]]}, 32'h10000);
    chk(xa_log[x0[3:0]+1] == 32'h0002_FFF0 && xl_log[x0[3:0]+1] == 17'h10,
        "R7 region ending on boundary accepted", xa_log[x0[3:0]+1], 32'h0002_FFF0);
    chk(xa_log[x0[3:0]+2] == 32'h1234_0100 && xl_log[x0[3:0]+2] == 17'h200,
        "R3 third region fields", xa_log[x0[3:0]+2], 32'h1234_0100);
    chk(xd_log[x0[3:0]+2] == 1'b0, "R3 direction zero", {31'b0, xd_log[x0[3:0]+2]}, 0);
    for (int i = 0; i < 6; i++)
      chk(rd_log[r0[5:0]+i[5:0]] == 32'h40 + 4 * i, "R2 pointer stride of 8",
          rd_log[r0[5:0]+i[5:0]], 32'h40 + 4 * i);
    chk(seen == done_cyc + 1, "R5 chain done timing", seen, done_cyc + 1);
    stop_run("R9 clear after chain");
  endtask

  task automatic t_misalign();
    int x0, seen;
    clear_mem();
    mem[0] = 32'h0000_1001; mem[1] = 32'h8000_0004;
    x0 = nxf;
    run(32'h0, 1'b0, seen);
    chk(err && !done, "R6 misaligned raises error", {done, err}, 2'b01);
    chk(nxf == x0, "R6 no transfer issued", nxf - x0, 0);
    stop_run("R9 clear after error");
  endtask

  task automatic t_cross();
    int x0, seen;
    clear_mem();
    mem[4] = 32'h0000_2000; mem[5] = 32'h0000_0040;
    mem[6] = 32'h0003_FFF0; mem[7] = 32'h8000_0011;
    x0 = nxf;
    run(32'h10, 1'b0, seen);
    chk(err && !done, "R7 crossing raises error", {done, err}, 2'b01);
    chk(nxf - x0 == 1 && xa_log[x0[3:0]] == 32'h2000, "R7 only first region moved",
        nxf - x0, 1);
    stop_run("R9 clear after crossing");
  endtask

  task automatic t_fetch_err();
    int x0, r0, seen;
    clear_mem();
    mem[8] = 32'h0000_3000; mem[9] = 32'h0000_0020;
    mem[10] = 32'h0000_5000; mem[11] = 32'h8000_0020;
    fail_addr = 32'h2C; fail_en = 1'b1;
    x0 = nxf; r0 = nrd;
    run(32'h20, 1'b0, seen);
    chk(err && !done, "R8 read error raises error", {done, err}, 2'b01);
    chk(nxf - x0 == 1, "R8 walk ends at failing read", nxf - x0, 1);
    repeat (3) @(negedge clk);
    chk(nrd - r0 == 4 && !mem_req, "R8 no read after fault", nrd - r0, 4);
    fail_en = 1'b0;
    stop_run("R9 clear after read error");
  endtask

  task automatic t_abort();
    int x0, r0;
    clear_mem();
    mem[12] = 32'h0000_6000; mem[13] = 32'h0000_0080;
    mem[14] = 32'h0000_7000; mem[15] = 32'h8000_0080;
    hold = 1'b1;
    x0 = nxf;
    @(negedge clk); tbase = 32'h30; start = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (xfer_req) break;
    end
    chk(xfer_req && busy, "R3 request held while mover stalls", {xfer_req, busy}, 2'b11);
    start = 1'b0;
    @(negedge clk);
    chk(!busy && !xfer_req && !mem_req && !done && !err, "R9 abort mid transfer",
        {busy, xfer_req, mem_req, done, err}, 0);
    hold = 1'b0;
    r0 = nrd;
    repeat (6) @(negedge clk);
    chk(nrd == r0 && nxf == x0 && !busy, "R9 nothing after abort", nrd - r0, 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_chain();
    t_misalign();
    t_cross();
    t_fetch_err();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule